// File: doc/BRIEF.md
# Audio De-emphasis Filter with Mode Selection

This block sits on a recovered 24-bit PCM sample stream and removes the 50/15 µs pre-emphasis that a source may have applied. It does this with a first-order IIR shelving filter. There are four coefficient sets, one each for 32, 44.1, 48 and 96 kHz sample rates. A mode decoder picks the coefficient set, or bypasses the filter.

- In automatic mode the decoder reads the channel-status pre-emphasis flag and the 4-bit rate code.
- In manual mode it reads a 3-bit control code.
- A strap input can force automatic mode whatever the mode pin says.
- Any combination without a supported rate passes samples through bit-exactly.

Samples enter and leave on valid/ready streams. The input is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or `out_ready` is high, so the whole two-stage pipeline stalls as one unit. While `out_valid` is high and `out_ready` is low, `out_data` and `out_valid` hold their values. The control inputs are sampled together with each accepted sample.

Top module: `deemph_filter`

## Requirements
- R1: With `auto_mode`=1 (or `fixed_cfg`=1) and `cs_preemph`=1, `cs_rate` 4'b0000 selects 44.1 kHz, 4'b0010 selects 48 kHz, 4'b0011 selects 32 kHz and 4'b1010 selects 96 kHz. All other twelve codes select bypass.
- R2: With `auto_mode`=0, `fixed_cfg`=0 and `cs_preemph`=1, the code `man_sel` (bit 2 = rate group, bits 1:0 = curve select) is decoded as follows: 3'b000 gives 44.1 kHz, 3'b010 gives 48 kHz, 3'b011 gives 32 kHz, 3'b110 gives 96 kHz, and 3'b001, 3'b100, 3'b101 and 3'b111 give bypass.
- R3: `cs_preemph`=0 selects bypass in both automatic and manual mode.
- R4: `fixed_cfg`=1 forces automatic decoding, and `man_sel` and `auto_mode` have no effect on the output.
- R5: In bypass, `out_data` equals the accepted input sample bit for bit.
- R6: A filtered output is y = sat24((B0·x + B1·xp + A·yp + 2^17) >>> 18), with signed coefficients in 18 fractional bits. The sets are: 32 kHz (122334, 2497, 137313), 44.1 kHz (112562, −15651, 165233), 48 kHz (110281, −19887, 171750), 96 kHz (95955, −46493, 212682). Here xp and yp are the previous input and the previous saturated output.
- R7: When a sample's mode differs from the mode of the previous sample, that sample is computed with xp = yp = 0. A bypassed sample also clears xp and yp.
- R8: With `out_ready` high, a sample accepted on clock edge k appears with `out_valid`=1 after edge k+1, and not after edge k. This holds in both filter and bypass modes.
- R9: While `out_valid`=1 and `out_ready`=0, `out_valid` and `out_data` hold and `in_ready` is 0. When the output register is empty, `in_ready` is 1.
- R10: After reset, `out_valid` is 0, `in_ready` is 1, and the filter history is zero with the last mode set to bypass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Block can accept a sample |
| in_data | input | 24 | Signed input sample |
| cs_preemph | input | 1 | Channel-status pre-emphasis flag |
| cs_rate | input | 4 | Channel-status sample-rate code |
| auto_mode | input | 1 | 1 = decode from channel status |
| fixed_cfg | input | 1 | Strap forcing automatic decoding |
| man_sel | input | 3 | Manual code {rate group, curve[1:0]} |
| out_valid | output | 1 | Output sample valid |
| out_ready | input | 1 | Downstream accepts the output |
| out_data | output | 24 | Signed output sample |

## Verification
The bench sweeps all sixteen rate codes and all eight manual codes with an impulse.

- A decoder with a missing or swapped entry shows up as the wrong leading coefficient, or as a filtered value where a bit-exact copy is expected.
- It sends streams of filtered samples through a mode switch. A design that keeps stale history, or that mis-rounds, produces tail values that differ from the model.
- It checks the strap with manual codes that would otherwise bypass.
- It probes the exact cycle the output appears, and stalls the output for several cycles. A pipeline that drops, duplicates or changes a held sample fails these checks.

// File: rtl/deemph_pkg.sv
package deemph_pkg;
  localparam int FRAC   = 18;
  localparam int COEF_W = 20;

  typedef enum logic [2:0] {
    DM_OFF = 3'd0,
    DM_32  = 3'd1,
    DM_44  = 3'd2,
    DM_48  = 3'd3,
    DM_96  = 3'd4
  } dmode_e;

  typedef struct packed {
    logic signed [COEF_W-1:0] b0;
    logic signed [COEF_W-1:0] b1;
    logic signed [COEF_W-1:0] fb;
  } coef_t;

  function automatic coef_t coef_of(dmode_e m);
    coef_t c;
    case (m)
      DM_32:   c = '{b0: 20'sd122334, b1: 20'sd2497,    fb: 20'sd137313};
      DM_44:   c = '{b0: 20'sd112562, b1: -20'sd15651,  fb: 20'sd165233};
      DM_48:   c = '{b0: 20'sd110281, b1: -20'sd19887,  fb: 20'sd171750};
      DM_96:   c = '{b0: 20'sd95955,  b1: -20'sd46493,  fb: 20'sd212682};
      default: c = '0;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/deemph_mode_sel.sv
module deemph_mode_sel
  import deemph_pkg::*;
(
  input  logic       auto_mode,
  input  logic       fixed_cfg,
  input  logic       cs_preemph,
  input  logic [3:0] cs_rate,
  input  logic [2:0] man_sel,
  output dmode_e     mode
);
  logic   use_auto;
  dmode_e auto_m, man_m;

  assign use_auto = auto_mode | fixed_cfg;

  always_comb begin
    case (cs_rate)
      4'b0000: auto_m = DM_44;
      4'b0010: auto_m = DM_48;
      4'b0011: auto_m = DM_32;
      4'b1010: auto_m = DM_96;
      default: auto_m = DM_OFF;
    endcase
  end

  always_comb begin
    case (man_sel)
      3'b000:  man_m = DM_44;
      3'b010:  man_m = DM_48;
      3'b011:  man_m = DM_32;
      3'b110:  man_m = DM_96;
      default: man_m = DM_OFF;
    endcase
  end

  always_comb begin
    if (!cs_preemph)   mode = DM_OFF;
    else if (use_auto) mode = auto_m;
    else               mode = man_m;
  end
endmodule

// File: rtl/deemph_iir_core.sv
module deemph_iir_core
  import deemph_pkg::*;
#(
  parameter int DATA_W = 24
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     adv,
  input  logic                     in_valid,
  input  dmode_e                   in_mode,
  input  logic signed [DATA_W-1:0] in_x,
  output logic                     out_valid,
  output logic signed [DATA_W-1:0] out_y
);
  localparam int PROD_W = DATA_W + COEF_W;
  localparam int ACC_W  = PROD_W + 2;
  localparam logic signed [ACC_W-1:0] RND  = ACC_W'(1) <<< (FRAC - 1);
  localparam logic signed [ACC_W-1:0] VMAX = ACC_W'((64'sd1 <<< (DATA_W - 1)) - 1);
  localparam logic signed [ACC_W-1:0] VMIN = -(ACC_W'(64'sd1 <<< (DATA_W - 1)));

  logic signed [DATA_W-1:0] xp, yp, hx, hy, sat, y_next;
  logic signed [PROD_W-1:0] p0, p1, p2;
  logic signed [ACC_W-1:0]  acc, sh;
  dmode_e last_mode;
  coef_t  c;
  logic   fresh;

  assign c     = coef_of(in_mode);
  assign fresh = (in_mode != last_mode);
  assign hx    = fresh ? '0 : xp;
  assign hy    = fresh ? '0 : yp;

  assign p0  = PROD_W'(c.b0) * PROD_W'(in_x);
  assign p1  = PROD_W'(c.b1) * PROD_W'(hx);
  assign p2  = PROD_W'(c.fb) * PROD_W'(hy);
  assign acc = ACC_W'(p0) + ACC_W'(p1) + ACC_W'(p2) + RND;
  assign sh  = acc >>> FRAC;

  always_comb begin
    if (sh > VMAX)      sat = VMAX[DATA_W-1:0];
    else if (sh < VMIN) sat = VMIN[DATA_W-1:0];
    else                sat = sh[DATA_W-1:0];
  end

  assign y_next = (in_mode == DM_OFF) ? in_x : sat;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_y     <= '0;
      xp        <= '0;
      yp        <= '0;
      last_mode <= DM_OFF;
    end else if (adv) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_y     <= y_next;
        last_mode <= in_mode;
        if (in_mode == DM_OFF) begin
          xp <= '0;
          yp <= '0;
        end else begin
          xp <= in_x;
          yp <= sat;
        end
      end
    end
  end

  // R5: bypassed samples leave the core unchanged
  assert_bypass_exact_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && in_valid && in_mode == DM_OFF) |=> (out_valid && out_y == $past(in_x)));
endmodule

// File: rtl/deemph_filter.sv
module deemph_filter
  import deemph_pkg::*;
#(
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              cs_preemph,
  input  logic [3:0]        cs_rate,
  input  logic              auto_mode,
  input  logic              fixed_cfg,
  input  logic [2:0]        man_sel,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);
  dmode_e                   sel_mode, s1_mode;
  logic                     s1_valid, adv;
  logic signed [DATA_W-1:0] s1_x, core_y;

  deemph_mode_sel u_sel (
    .auto_mode  (auto_mode),
    .fixed_cfg  (fixed_cfg),
    .cs_preemph (cs_preemph),
    .cs_rate    (cs_rate),
    .man_sel    (man_sel),
    .mode       (sel_mode)
  );

  assign adv      = out_ready | ~out_valid;
  assign in_ready = adv;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_x     <= '0;
      s1_mode  <= DM_OFF;
    end else if (adv) begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_x    <= in_data;
        s1_mode <= sel_mode;
      end
    end
  end

  deemph_iir_core #(.DATA_W(DATA_W)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .adv       (adv),
    .in_valid  (s1_valid),
    .in_mode   (s1_mode),
    .in_x      (s1_x),
    .out_valid (out_valid),
    .out_y     (core_y)
  );

  assign out_data = core_y;

  // R9: stalled output holds
  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R8: accepted sample reaches the output one edge later under open flow
  assert_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && out_ready) ##1 out_ready |=> out_valid);

  // R3: no pre-emphasis flag, no filter
  assert_no_preemph_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_preemph |-> (sel_mode == DM_OFF));

  // R1: unsupported channel-status codes bypass
  assert_auto_unsupported_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ((auto_mode || fixed_cfg) && !(cs_rate inside {4'b0000, 4'b0010, 4'b0011, 4'b1010}))
      |-> (sel_mode == DM_OFF));
endmodule

// File: tb/tb_deemph_filter.sv
module tb_deemph_filter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [23:0] in_data = '0;
  logic        cs_preemph = 1'b0;
  logic [3:0]  cs_rate = '0;
  logic        auto_mode = 1'b1;
  logic        fixed_cfg = 1'b0;
  logic [2:0]  man_sel = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [23:0] out_data;

  int total = 0;
  int bad = 0;

  // model state: mode 0 bypass, 1=32k 2=44.1k 3=48k 4=96k
  int     m_last = 0;
  longint m_xp = 0;
  longint m_yp = 0;

  always #10 clk = ~clk;

  deemph_filter dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .cs_preemph(cs_preemph), .cs_rate(cs_rate),
    .auto_mode(auto_mode), .fixed_cfg(fixed_cfg), .man_sel(man_sel),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_mode();
    if (!cs_preemph) return 0;
    if (auto_mode || fixed_cfg) begin
      case (cs_rate)
        4'b0000: return 2;
        4'b0010: return 3;
        4'b0011: return 1;
        4'b1010: return 4;
        default: return 0;
      endcase
    end
    case (man_sel)
      3'b000: return 2;
      3'b010: return 3;
      3'b011: return 1;
      3'b110: return 4;
      default: return 0;
    endcase
  endfunction

  function automatic longint model_step(input logic [23:0] din, input int md);
    longint x, b0, b1, a, hx, hy, y;
    x = longint'($signed(din));
    if (md == 0) begin
      m_last = 0; m_xp = 0; m_yp = 0;
      return x;
    end
    case (md)
      1: begin b0 = 122334; b1 = 2497;   a = 137313; end
      2: begin b0 = 112562; b1 = -15651; a = 165233; end
      3: begin b0 = 110281; b1 = -19887; a = 171750; end
      default: begin b0 = 95955; b1 = -46493; a = 212682; end
    endcase
    hx = (md != m_last) ? 0 : m_xp;
    hy = (md != m_last) ? 0 : m_yp;
    y = (b0 * x + b1 * hx + a * hy + 131072) >>> 18;
    if (y > 8388607) y = 8388607;
    if (y < -8388608) y = -8388608;
    m_last = md; m_xp = x; m_yp = y;
    return y;
  endfunction

  // drive one sample, check it one edge after acceptance
  task automatic send_chk(input logic [23:0] d, input string req);
    longint e;
    e = model_step(d, exp_mode());
    in_data = d; in_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
    @(posedge clk); @(negedge clk);
    chk(out_valid && longint'($signed(out_data)) == e, req, longint'($signed(out_data)), e);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(out_valid == 1'b0, "R10 out_valid", out_valid, 0);
    chk(in_ready == 1'b1, "R10 in_ready", in_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_auto_sweep();
    auto_mode = 1'b1; fixed_cfg = 1'b0; cs_preemph = 1'b1; man_sel = 3'b001;
    for (int r = 0; r < 16; r++) begin
      cs_rate = 4'(r);
      send_chk(24'h100000, "R1 auto decode");
    end
  endtask

  task automatic t_manual_sweep();
    auto_mode = 1'b0; fixed_cfg = 1'b0; cs_preemph = 1'b1; cs_rate = 4'b1111;
    for (int c = 0; c < 8; c++) begin
      man_sel = 3'(c);
      send_chk(24'h0C0000, "R2 manual decode");
    end
  endtask

  task automatic t_no_preemph();
    cs_preemph = 1'b0;
    auto_mode = 1'b1; cs_rate = 4'b0000;
    send_chk(24'h123456, "R3 auto no preemph");
    auto_mode = 1'b0; man_sel = 3'b000;
    send_chk(24'hABCDEF, "R3 manual no preemph");
  endtask

  task automatic t_fixed();
    fixed_cfg = 1'b1; auto_mode = 1'b0; cs_preemph = 1'b1;
    cs_rate = 4'b0011; man_sel = 3'b111;
    send_chk(24'h200000, "R4 strap forces auto 32k");
    cs_rate = 4'b0001; man_sel = 3'b000;
    send_chk(24'h054321, "R4 strap ignores manual");
    fixed_cfg = 1'b0;
  endtask

  task automatic t_bypass();
    auto_mode = 1'b1; cs_preemph = 1'b1; cs_rate = 4'b0101;
    send_chk(24'h800000, "R5 bypass min");
    send_chk(24'h7FFFFF, "R5 bypass max");
    send_chk(24'hF0F0F0, "R5 bypass pattern");
  endtask

  task automatic t_history();
    auto_mode = 1'b1; cs_preemph = 1'b1; cs_rate = 4'b1010;
    send_chk(24'h7FFFFF, "R6 96k step 0");
    for (int i = 1; i < 6; i++) send_chk(24'h7FFFFF, "R6 96k step tail");
    send_chk(24'h800000, "R6 96k negative swing");
    cs_rate = 4'b0000;
    send_chk(24'h400000, "R7 switch clears history");
    send_chk(24'hC00000, "R6 44k second sample");
    cs_rate = 4'b0111;
    send_chk(24'h000111, "R7 bypass clears");
    cs_rate = 4'b0000;
    send_chk(24'h400000, "R7 restart after bypass");
  endtask

  task automatic t_latency();
    longint e;
    cs_preemph = 1'b1; auto_mode = 1'b1; cs_rate = 4'b0010;
    e = model_step(24'h010000, exp_mode());
    in_data = 24'h010000; in_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1'b0, "R8 not after first edge", out_valid, 0);
    @(posedge clk); @(negedge clk);
    chk(out_valid == 1'b1 && longint'($signed(out_data)) == e, "R8 after second edge",
        longint'($signed(out_data)), e);
    @(posedge clk); @(negedge clk);
  endtask

  task automatic t_stall();
    longint e;
    logic [23:0] held;
    cs_preemph = 1'b1; auto_mode = 1'b1; cs_rate = 4'b0011;
    out_ready = 1'b0;
    e = model_step(24'h300000, exp_mode());
    in_data = 24'h300000; in_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
    @(posedge clk); @(negedge clk);
    chk(out_valid && longint'($signed(out_data)) == e, "R9 stalled output value",
        longint'($signed(out_data)), e);
    chk(in_ready == 1'b0, "R9 in_ready low when stalled", in_ready, 0);
    held = out_data;
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); @(negedge clk);
    end
    chk(out_valid && out_data == held, "R9 output holds", out_data, held);
    out_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    chk(out_valid == 1'b0, "R9 drained", out_valid, 0);
    chk(in_ready == 1'b1, "R9 ready when empty", in_ready, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_auto_sweep();
    t_manual_sweep();
    t_no_preemph();
    t_fixed();
    t_bypass();
    t_history();
    t_latency();
    t_stall();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule